// File: doc/BRIEF.md
# Shared Time-Base Counter Fabric

This block supplies time bases to a bank of 24 timer channels. Each channel owns a 24-bit up-counter. A per-channel divider steps that counter, and it is itself paced by a single module-wide prescaler. Four 24-bit shared buses spread time bases across the bank. Bus A carries either the last channel's counter or an externally supplied time base. The other three buses each carry the counter of the first channel in one group of eight. Every channel selects which value it presents: its own counter, bus A, or the bus of its own group.

Software sets each channel up through a small register port. Each channel has a counter register and a control register holding the source select, the divider ratio and a freeze enable. A module-wide freeze request stops every channel whose freeze enable is set. The register port keeps working while channels are frozen, and a frozen counter continues from its held value once the request drops. The block presents each channel's selected value and the four bus values as registered outputs.

Top module: `tbn_fabric`

## Requirements
- R1: While `rst` is high, every counter, every control register, `reg_rd`, `tb_o` and `bus_o` are zero.
- R2: With `gpre_div` = N, the module prescaler issues one enable pulse every N+1 clocks (N from 0 to 255).
- R3: With control bits [3:2] = D, a channel counter advances by exactly one once every (N+1)(D+1) clocks and by no other step unless written.
- R4: A counter at 0xFFFFFF advances to 0x000000.
- R5: Bus A (`bus_o[23:0]`) carries channel 23's counter when `busa_ext` is 0, and `ext_tb` when it is 1.
- R6: Bus B (`bus_o[47:24]`), bus C (`bus_o[71:48]`) and bus D (`bus_o[95:72]`) carry the counters of channels 0, 8 and 16.
- R7: Control bits [1:0] choose a channel's output: 00 its own counter, 01 bus A, 10 its group bus (channels 0-7 bus B, 8-15 bus C, 16-23 bus D), and 11 falls back to its own counter.
- R8: A channel freezes only while both `frz_req` and its control bit 4 are 1. A frozen channel's counter and divider hold.
- R9: When the freeze drops, the counter resumes counting from the value it held, without being cleared.
- R10: A write with `reg_fld`=0 loads the addressed counter on that clock edge, even while the channel is frozen. `reg_fld`=1 addresses the control register (bits [4:0]). `reg_rd` returns the register picked by `reg_ch`/`reg_fld` one clock later.
- R11: `tb_o` and `bus_o` are registered and show the counter and bus values of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpre_div | input | 8 | Module prescaler ratio minus one |
| frz_req | input | 1 | Module-wide freeze request |
| busa_ext | input | 1 | 1: bus A carries `ext_tb` |
| ext_tb | input | 24 | External time base |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 5 | Channel address for read and write |
| reg_fld | input | 1 | 0 counter register, 1 control register |
| reg_wd | input | 24 | Write data |
| reg_rd | output | 24 | Registered read data |
| tb_o | output | 576 | Selected time base per channel, channel c at [24c+23:24c] |
| bus_o | output | 96 | Buses A, B, C, D from low to high |

## Verification
The rate check runs under several pairs of module and channel divider ratios, including the extreme module ratio of 256. For each pair it measures the counter advance over a whole number of periods, so a fault in either divider, or in the order they are applied in, shows up as a wrong count no matter what phase the dividers start in. Source selection is tested with distinct frozen values loaded into the four bus-driving channels, so that every select code and every group maps to one value that cannot be mistaken for another. Freeze is tested with the request alone, with the enable alone, and with both. It is also tested across a release, where an exact resume value separates a counter that held from one that was cleared or kept counting.

// File: rtl/tbn_pkg.sv
package tbn_pkg;
  typedef enum logic [1:0] {
    SEL_OWN  = 2'b00,
    SEL_BUSA = 2'b01,
    SEL_GRP  = 2'b10,
    SEL_RSV  = 2'b11
  } tb_sel_e;

  typedef struct packed {
    logic       frz_en;
    logic [1:0] pdiv;
    tb_sel_e    sel;
  } ch_ctrl_t;

  localparam int CTLW = $bits(ch_ctrl_t);
endpackage

// File: rtl/tbn_gpresc.sv
module tbn_gpresc #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/tbn_channel.sv
module tbn_channel
  import tbn_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gtick,
  input  logic          hold,
  input  logic          cnt_we,
  input  logic          ctl_we,
  input  logic [CW-1:0] wd,
  output ch_ctrl_t      ctl,
  output logic [CW-1:0] cnt
);
  logic [1:0] pcnt;
  logic       step;
  logic       wrap;

  assign step = gtick & ~hold;
  assign wrap = (pcnt >= ctl.pdiv);

  always_ff @(posedge clk) begin
    if (rst)         ctl <= '0;
    else if (ctl_we) ctl <= ch_ctrl_t'(wd[CTLW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst)       pcnt <= '0;
    else if (step) pcnt <= wrap ? 2'd0 : pcnt + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (cnt_we)       cnt <= wd;
    else if (step && wrap) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tbn_busnet.sv
module tbn_busnet
  import tbn_pkg::*;
#(
  parameter int NCH  = 24,
  parameter int GRP  = 8,
  parameter int CW   = 24,
  localparam int NBUS = NCH / GRP + 1
) (
  input  logic [NCH-1:0][CW-1:0]  cnt,
  input  logic [NCH-1:0][1:0]     sel,
  input  logic                    busa_ext,
  input  logic [CW-1:0]           ext_tb,
  output logic [NBUS-1:0][CW-1:0] bus,
  output logic [NCH-1:0][CW-1:0]  tb
);
  assign bus[0] = busa_ext ? ext_tb : cnt[NCH-1];

  for (genvar g = 0; g < NBUS - 1; g++) begin : g_grp
    assign bus[g+1] = cnt[g*GRP];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    localparam int GB = c / GRP + 1;
    tb_sel_e s;
    assign s = tb_sel_e'(sel[c]);
    always_comb begin
      case (s)
        SEL_BUSA: tb[c] = bus[0];
        SEL_GRP:  tb[c] = bus[GB];
        default:  tb[c] = cnt[c];
      endcase
    end
  end
endmodule

// File: rtl/tbn_fabric.sv
module tbn_fabric
  import tbn_pkg::*;
#(
  parameter int NCH  = 24,
  parameter int GRP  = 8,
  parameter int CW   = 24,
  parameter int GDW  = 8,
  localparam int CHW  = $clog2(NCH),
  localparam int NBUS = NCH / GRP + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [GDW-1:0]      gpre_div,
  input  logic                frz_req,
  input  logic                busa_ext,
  input  logic [CW-1:0]       ext_tb,
  input  logic                reg_we,
  input  logic [CHW-1:0]      reg_ch,
  input  logic                reg_fld,
  input  logic [CW-1:0]       reg_wd,
  output logic [CW-1:0]       reg_rd,
  output logic [NCH*CW-1:0]   tb_o,
  output logic [NBUS*CW-1:0]  bus_o
);
  logic                    gtick;
  logic [NCH-1:0][CW-1:0]  cnt;
  ch_ctrl_t [NCH-1:0]      ctl;
  logic [NCH-1:0][1:0]     sel;
  logic [NCH-1:0]          frz;
  logic [NCH-1:0]          cnt_we;
  logic [NCH-1:0]          ctl_we;
  logic [NBUS-1:0][CW-1:0] bus_d;
  logic [NCH-1:0][CW-1:0]  tb_d;
  logic [NBUS-1:0][CW-1:0] bus_q;
  logic [NCH-1:0][CW-1:0]  tb_q;

  tbn_gpresc #(.DW(GDW)) u_gpresc (
    .clk  (clk),
    .rst  (rst),
    .div  (gpre_div),
    .tick (gtick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign cnt_we[c] = reg_we & ~reg_fld & (reg_ch == CHW'(c));
    assign ctl_we[c] = reg_we &  reg_fld & (reg_ch == CHW'(c));
    assign frz[c]    = frz_req & ctl[c].frz_en;
    assign sel[c]    = ctl[c].sel;

    tbn_channel #(.CW(CW)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .gtick  (gtick),
      .hold   (frz[c]),
      .cnt_we (cnt_we[c]),
      .ctl_we (ctl_we[c]),
      .wd     (reg_wd),
      .ctl    (ctl[c]),
      .cnt    (cnt[c])
    );
  end

  tbn_busnet #(.NCH(NCH), .GRP(GRP), .CW(CW)) u_net (
    .cnt      (cnt),
    .sel      (sel),
    .busa_ext (busa_ext),
    .ext_tb   (ext_tb),
    .bus      (bus_d),
    .tb       (tb_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q  <= '0;
      tb_q   <= '0;
      reg_rd <= '0;
    end else begin
      bus_q <= bus_d;
      tb_q  <= tb_d;
      if (int'(reg_ch) >= NCH) reg_rd <= '0;
      else if (reg_fld)        reg_rd <= {{(CW-CTLW){1'b0}}, ctl[reg_ch]};
      else                     reg_rd <= cnt[reg_ch];
    end
  end

  assign bus_o = bus_q;
  assign tb_o  = tb_q;
endmodule

// File: rtl/tbn_fabric_chk.sv
module tbn_fabric_chk #(
  parameter int NCH  = 24,
  parameter int GRP  = 8,
  parameter int CW   = 24,
  parameter int GDW  = 8,
  parameter int NBUS = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    gtick,
  input logic [GDW-1:0]          gpre_div,
  input logic                    busa_ext,
  input logic [CW-1:0]           ext_tb,
  input logic [NBUS*CW-1:0]      bus_o,
  input logic [NCH-1:0][CW-1:0]  cnt,
  input logic [NCH-1:0]          frz,
  input logic [NCH-1:0]          cwe
);
  // R2: back-to-back pulses only when the ratio is one
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    gtick && $past(gtick) |-> $past(gpre_div) == '0)
    else $error("a_r2_tick_gap");

  // R5, R11: bus A follows the external time base when selected
  a_r5_busa_ext: assert property (@(posedge clk) disable iff (rst)
    $past(busa_ext) |-> bus_o[CW-1:0] == $past(ext_tb))
    else $error("a_r5_busa_ext");

  for (genvar g = 1; g < NBUS; g++) begin : g_bus
    // R6, R11: group bus g carries the first channel of group g-1
    a_r6_grp_bus: assert property (@(posedge clk) disable iff (rst)
      1'b1 |-> bus_o[g*CW +: CW] == $past(cnt[(g-1)*GRP]))
      else $error("a_r6_grp_bus");
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R8: a frozen, unwritten counter stays put
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      $past(frz[c]) && !$past(cwe[c]) |-> $stable(cnt[c]))
      else $error("a_r8_hold");

    // R3, R4: without a write the counter moves by zero or one
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
      !$past(cwe[c]) |->
        (cnt[c] == $past(cnt[c])) || (cnt[c] == CW'($past(cnt[c]) + 1'b1)))
      else $error("a_r3_step");
  end
endmodule

bind tbn_fabric tbn_fabric_chk #(
  .NCH(NCH), .GRP(GRP), .CW(CW), .GDW(GDW), .NBUS(NBUS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .gtick    (gtick),
  .gpre_div (gpre_div),
  .busa_ext (busa_ext),
  .ext_tb   (ext_tb),
  .bus_o    (bus_o),
  .cnt      (cnt),
  .frz      (frz),
  .cwe      (cnt_we)
);

// File: tb/tbn_fabric_test.sv
module tbn_fabric_test;
  localparam int NCH = 24;
  localparam int CW  = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [7:0]        gpre_div = '0;
  logic              frz_req = 1'b0;
  logic              busa_ext = 1'b0;
  logic [CW-1:0]     ext_tb = '0;
  logic              reg_we = 1'b0;
  logic [4:0]        reg_ch = '0;
  logic              reg_fld = 1'b0;
  logic [CW-1:0]     reg_wd = '0;
  logic [CW-1:0]     reg_rd;
  logic [NCH*CW-1:0] tb_o;
  logic [4*CW-1:0]   bus_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tbn_fabric uut (
    .clk(clk), .rst(rst), .gpre_div(gpre_div), .frz_req(frz_req),
    .busa_ext(busa_ext), .ext_tb(ext_tb), .reg_we(reg_we), .reg_ch(reg_ch),
    .reg_fld(reg_fld), .reg_wd(reg_wd), .reg_rd(reg_rd), .tb_o(tb_o), .bus_o(bus_o)
  );

  typedef struct packed {
    logic [7:0] gd;
    logic [1:0] cd;
    logic [7:0] m;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd0,   2'd0, 8'd10},
    '{8'd0,   2'd3, 8'd7},
    '{8'd4,   2'd1, 8'd5},
    '{8'd2,   2'd2, 8'd9},
    '{8'd255, 2'd0, 8'd3},
    '{8'd255, 2'd3, 8'd2}
  };

  function automatic logic [CW-1:0] tbv(int c);
    return tb_o[c*CW +: CW];
  endfunction

  function automatic logic [CW-1:0] busv(int b);
    return bus_o[b*CW +: CW];
  endfunction

  task automatic chk(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int ch, logic fld, logic [CW-1:0] d);
    reg_we  = 1'b1;
    reg_ch  = 5'(ch);
    reg_fld = fld;
    reg_wd  = d;
    @(negedge clk);
    reg_we  = 1'b0;
  endtask

  task automatic rd(int ch, logic fld, output logic [CW-1:0] d);
    reg_ch  = 5'(ch);
    reg_fld = fld;
    @(negedge clk);
    d = reg_rd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL all watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [CW-1:0] a, b, r;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 tb_o", (|tb_o) ? 24'd1 : 24'd0, 24'd0);
    chk("R1 bus_o", (|bus_o) ? 24'd1 : 24'd0, 24'd0);
    chk("R1 reg_rd", reg_rd, 24'd0);
    rst = 1'b0;
    @(negedge clk);

    // R2, R3: rate table, channel 5 own counter
    for (int i = 0; i < 6; i++) begin
      gpre_div = VECS[i].gd;
      wr(5, 1'b1, {22'd0, VECS[i].cd, 2'b00});
      repeat (1100) @(negedge clk);
      a = tbv(5);
      repeat ((int'(VECS[i].gd) + 1) * (int'(VECS[i].cd) + 1) * int'(VECS[i].m))
        @(negedge clk);
      b = tbv(5);
      chk($sformatf("R2 R3 vec%0d", i), b - a, 24'(VECS[i].m));
    end

    gpre_div = 8'd0;
    frz_req  = 1'b1;
    // R8, R10: freeze the bus-driving channels and load distinct values
    wr(0, 1'b1, 24'h10);  wr(0,  1'b0, 24'h111111);
    wr(8, 1'b1, 24'h10);  wr(8,  1'b0, 24'h222222);
    wr(16, 1'b1, 24'h10); wr(16, 1'b0, 24'h333333);
    wr(23, 1'b1, 24'h10); wr(23, 1'b0, 24'h444444);
    wr(5, 1'b1, 24'h13);  wr(5,  1'b0, 24'h555555);
    repeat (2) @(negedge clk);
    chk("R5 bus A from ch23", busv(0), 24'h444444);
    chk("R6 bus B", busv(1), 24'h111111);
    chk("R6 bus C", busv(2), 24'h222222);
    chk("R6 bus D", busv(3), 24'h333333);
    busa_ext = 1'b1;
    ext_tb   = 24'hABCDEF;
    @(negedge clk);
    chk("R5 bus A external", busv(0), 24'hABCDEF);

    // R7: source selection
    wr(3, 1'b1, 24'h2);  @(negedge clk);
    chk("R7 ch3 group bus B", tbv(3), 24'h111111);
    wr(12, 1'b1, 24'h2); @(negedge clk);
    chk("R7 ch12 group bus C", tbv(12), 24'h222222);
    wr(20, 1'b1, 24'h2); @(negedge clk);
    chk("R7 ch20 group bus D", tbv(20), 24'h333333);
    wr(20, 1'b1, 24'h1); @(negedge clk);
    chk("R7 ch20 bus A", tbv(20), 24'hABCDEF);
    chk("R7 ch5 code 11 own", tbv(5), 24'h555555);

    // R8: hold while frozen
    repeat (30) @(negedge clk);
    chk("R8 frozen hold", tbv(5), 24'h555555);
    rd(5, 1'b0, r);
    chk("R10 read counter", r, 24'h555555);
    rd(5, 1'b1, r);
    chk("R10 read control", r, 24'h13);

    // R8: request without enable keeps counting
    a = tbv(6);
    repeat (10) @(negedge clk);
    chk("R8 enable off runs", tbv(6) - a, 24'd10);

    // R10: write while frozen
    wr(5, 1'b0, 24'h000100);
    @(negedge clk);
    chk("R10 frozen write", tbv(5), 24'h000100);

    // R9: resume from held value
    frz_req = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 resume", tbv(5), 24'h000109);

    // R4: wrap
    frz_req = 1'b1;
    wr(5, 1'b0, 24'hFFFFFF);
    @(negedge clk);
    chk("R4 load max", tbv(5), 24'hFFFFFF);
    frz_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 wrap to zero", tbv(5), 24'h000000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule